// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the host-side master for a 12-bit, eight-channel serial analog-to-digital converter that runs in external-clock mode. A single request names the input channel, the coding (unipolar or bipolar) and the input type (single-ended or differential). The block then pulls chip select low and clocks 24 serial clock cycles. During the first byte it sends a control byte built from the request, and during the next two bytes it sends zeros. The converter returns its result over the last two bytes. The block discards the first received byte, takes the 12 result bits from their position inside the two padded bytes, extends the value to the output width and raises a done strobe for one system clock.

The serial clock comes from the system clock. Its high and low phases each last a programmable number of system clocks. An optional idle gap, with the serial clock held low, can be placed between bytes. A request whose phase length lies outside the legal serial-clock band is refused without touching the bus. A conversion whose sampling window runs past a fixed cycle ceiling is completed but flagged, because the converter's held sample degrades over a long window.

Top module: `adc_conv_seq`

## Requirements
- R1: The first byte on `spi_mosi`, most significant bit first, is {1, `req_chan[2:0]`, `req_unipolar`, `req_single`, 1, 1}.
- R2: Each accepted conversion produces exactly 24 rising edges of `spi_sclk`. `spi_mosi` is 0 during the second and third bytes.
- R3: `spi_cs_n` falls when the request is accepted and rises in the same cycle that `done` is raised, one phase after the last falling edge. `spi_sclk` is low whenever `spi_cs_n` is high.
- R4: The first received byte and the padding bits are ignored. The 12-bit result is {byte2[6:0], byte3[7:3]} of the received stream, most significant bit first.
- R5: `spi_miso` is sampled on each rising edge of `spi_sclk`. `spi_mosi` changes only while `spi_sclk` is low.
- R6: Each high phase and each low phase of `spi_sclk` inside a byte lasts `half_cfg` system clocks. The first low phase after chip select falls also lasts `half_cfg` clocks.
- R7: A request with `half_cfg` below HALF_MIN or above HALF_MAX is refused. `done` pulses with `rate_err`=1, `result`=0, and `spi_cs_n` stays high.
- R8: Between bytes, the low phase of `spi_sclk` is extended by `gap_cfg` system clocks.
- R9: `timeout_err` is 1 at `done` when LIMIT_CYC or more system clocks passed between acceptance and the 24th sampling edge. Otherwise it is 0.
- R10: In unipolar mode the result is zero-extended to OUT_W bits. In bipolar mode it is sign-extended from result bit 11.
- R11: `busy` is high from acceptance until chip select rises. Requests made while busy are ignored and start no second conversion.
- R12: `done` lasts one system clock. `result`, `rate_err` and `timeout_err` hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request, taken when not busy |
| req_chan | input | 3 | Channel select |
| req_unipolar | input | 1 | 1 = unipolar straight binary, 0 = bipolar two's complement |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| half_cfg | input | HALF_W | Serial clock phase length in system clocks |
| gap_cfg | input | GAP_W | Extra idle clocks between bytes |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | OUT_W | Extended 12-bit conversion result |
| rate_err | output | 1 | Request refused because of an illegal phase length |
| timeout_err | output | 1 | Sampling window exceeded the ceiling |
| spi_cs_n | output | 1 | Converter chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |

## Verification
Two functions can fall in the same system clock. In the cycle where the last phase of a conversion ends and chip select rises, the block clears `busy`, raises `done` and writes the result and flags. In the same cycle a new request may be present on the request inputs. The bench provokes this by pulsing a second request in the middle of a conversion. It then judges the outcome only at the ports: the captured control byte must belong to the first request, the converter model must see exactly one chip-select fall, and `result` must stay unchanged afterwards. The timeout ceiling interacts with the gap setting, so the bench runs one phase length twice, once with no gap and once with a gap large enough to cross the ceiling.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  localparam int FRAME_BITS = 24;
  localparam int BYTE_BITS  = 8;
  localparam int RES_BITS   = 12;
  localparam int PAD_LO     = 3;
  localparam int RX_KEEP    = RES_BITS + PAD_LO;
  localparam int BIT_CNT_W  = $clog2(FRAME_BITS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_TRAIL
  } seq_state_t;

  // start bit, channel, coding, input type, external-clock power bits
  function automatic logic [BYTE_BITS-1:0] make_ctrl(
    input logic [2:0] chan,
    input logic       unipolar,
    input logic       single
  );
    return {1'b1, chan, unipolar, single, 2'b11};
  endfunction

endpackage

// File: rtl/adc_phase_timer.sv
`timescale 1ns/1ps
module adc_phase_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign expired = (cnt == '0);

  AST_TIMER_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    (!load && !expired) |=> (cnt < $past(cnt))); // R6

endmodule

// File: rtl/adc_shift_pair.sv
`timescale 1ns/1ps
module adc_shift_pair
  import adc_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] load_word,
  input  logic                  shift_out,
  input  logic                  sample,
  input  logic                  miso,
  output logic                  mosi,
  output logic [RES_BITS-1:0]   res_bits
);

  logic [FRAME_BITS-1:0] tx;
  logic [RX_KEEP-1:0]    rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx <= '0;
    end else if (load) begin
      tx <= load_word;
    end else if (shift_out) begin
      tx <= {tx[FRAME_BITS-2:0], 1'b0};
    end
  end

  // only the newest RX_KEEP samples matter; older bits fall off the top
  always_ff @(posedge clk) begin
    if (rst || load) begin
      rx <= '0;
    end else if (sample) begin
      rx <= {rx[RX_KEEP-2:0], miso};
    end
  end

  assign mosi     = tx[FRAME_BITS-1];
  assign res_bits = rx[RX_KEEP-1:PAD_LO];

  AST_NO_SHIFT_AND_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    !(shift_out && sample)); // R5

endmodule

// File: rtl/adc_time_guard.sv
`timescale 1ns/1ps
module adc_time_guard #(
  parameter int LIMIT_CYC = 30000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic stop,
  output logic over
);

  localparam int CW = $clog2(LIMIT_CYC + 1);

  logic          active;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      over   <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      over   <= 1'b0;
    end else if (active) begin
      if (stop) begin
        active <= 1'b0;
      end
      if (cnt != CW'(LIMIT_CYC)) begin
        cnt <= cnt + CW'(1);
      end else begin
        over <= 1'b1;
      end
    end
  end

  AST_GUARD_STICKY: assert property (@(posedge clk) disable iff (rst)
    (over && !start) |=> over); // R9

  AST_GUARD_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!active && !start) |=> $stable(over)); // R9

endmodule

// File: rtl/adc_conv_seq.sv
`timescale 1ns/1ps
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int HALF_W    = 12,
  parameter int GAP_W     = 12,
  parameter int HALF_MIN  = 84,
  parameter int HALF_MAX  = 1250,
  parameter int LIMIT_CYC = 30000,
  parameter int OUT_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_chan,
  input  logic              req_unipolar,
  input  logic              req_single,
  input  logic [HALF_W-1:0] half_cfg,
  input  logic [GAP_W-1:0]  gap_cfg,
  output logic              busy,
  output logic              done,
  output logic [OUT_W-1:0]  result,
  output logic              rate_err,
  output logic              timeout_err,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int TW       = (HALF_W > GAP_W) ? HALF_W : GAP_W;
  localparam int EXT_BITS = OUT_W - RES_BITS;
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(FRAME_BITS - 1);

  seq_state_t           state;
  logic [HALF_W-1:0]    h_lat;
  logic [GAP_W-1:0]     g_lat;
  logic                 uni_lat;
  logic [BIT_CNT_W-1:0] bitcnt;

  logic                 accept;
  logic                 rate_ok;
  logic                 start_ok;
  logic                 t_load;
  logic [TW-1:0]        t_val;
  logic                 t_exp;
  logic                 last_fall;
  logic                 byte_end;
  logic                 use_gap;
  logic                 do_sample;
  logic                 do_shift;
  logic                 guard_stop;
  logic                 guard_over;
  logic [RES_BITS-1:0]  res_bits;
  logic [OUT_W-1:0]     res_ext;
  logic [TW-1:0]        h_m1;
  logic [TW-1:0]        g_m1;

  assign rate_ok  = (half_cfg >= HALF_W'(HALF_MIN)) && (half_cfg <= HALF_W'(HALF_MAX));
  assign accept   = (state == ST_IDLE) && req_valid;
  assign start_ok = accept && rate_ok;

  assign h_m1 = TW'(h_lat) - TW'(1);
  assign g_m1 = TW'(g_lat) - TW'(1);

  assign last_fall = (bitcnt == LAST_BIT);
  assign byte_end  = (bitcnt[2:0] == 3'd7);
  assign use_gap   = byte_end && !last_fall && (g_lat != '0);

  assign do_sample  = (state == ST_LOW)  && t_exp;
  assign do_shift   = (state == ST_HIGH) && t_exp;
  assign guard_stop = do_sample && last_fall;

  // phase timer reload selection
  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    unique case (state)
      ST_IDLE: begin
        if (start_ok) begin
          t_load = 1'b1;
          t_val  = TW'(half_cfg) - TW'(1);
        end
      end
      ST_LOW: begin
        if (t_exp) begin
          t_load = 1'b1;
          t_val  = h_m1;
        end
      end
      ST_HIGH: begin
        if (t_exp) begin
          t_load = 1'b1;
          t_val  = use_gap ? g_m1 : h_m1;
        end
      end
      ST_GAP: begin
        if (t_exp) begin
          t_load = 1'b1;
          t_val  = h_m1;
        end
      end
      default: begin
        t_load = 1'b0;
      end
    endcase
  end

  adc_phase_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  adc_shift_pair u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (start_ok),
    .load_word ({make_ctrl(req_chan, req_unipolar, req_single), 16'h0000}),
    .shift_out (do_shift),
    .sample    (do_sample),
    .miso      (spi_miso),
    .mosi      (spi_mosi),
    .res_bits  (res_bits)
  );

  adc_time_guard #(.LIMIT_CYC(LIMIT_CYC)) u_guard (
    .clk   (clk),
    .rst   (rst),
    .start (start_ok),
    .stop  (guard_stop),
    .over  (guard_over)
  );

  generate
    if (EXT_BITS > 0) begin : g_ext
      assign res_ext = uni_lat ? {{EXT_BITS{1'b0}}, res_bits}
                               : {{EXT_BITS{res_bits[RES_BITS-1]}}, res_bits};
    end else begin : g_noext
      assign res_ext = res_bits[OUT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      h_lat       <= '0;
      g_lat       <= '0;
      uni_lat     <= 1'b0;
      bitcnt      <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      result      <= '0;
      rate_err    <= 1'b0;
      timeout_err <= 1'b0;
      spi_cs_n    <= 1'b1;
      spi_sclk    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (rate_ok) begin
              h_lat    <= half_cfg;
              g_lat    <= gap_cfg;
              uni_lat  <= req_unipolar;
              bitcnt   <= '0;
              busy     <= 1'b1;
              spi_cs_n <= 1'b0;
              state    <= ST_LOW;
            end else begin
              done        <= 1'b1;
              rate_err    <= 1'b1;
              timeout_err <= 1'b0;
              result      <= '0;
            end
          end
        end
        ST_LOW: begin
          if (t_exp) begin
            spi_sclk <= 1'b1;
            state    <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (t_exp) begin
            spi_sclk <= 1'b0;
            bitcnt   <= bitcnt + BIT_CNT_W'(1);
            if (last_fall) begin
              state <= ST_TRAIL;
            end else if (use_gap) begin
              state <= ST_GAP;
            end else begin
              state <= ST_LOW;
            end
          end
        end
        ST_GAP: begin
          if (t_exp) begin
            state <= ST_LOW;
          end
        end
        ST_TRAIL: begin
          if (t_exp) begin
            spi_cs_n    <= 1'b1;
            busy        <= 1'b0;
            done        <= 1'b1;
            rate_err    <= 1'b0;
            timeout_err <= guard_over;
            result      <= res_ext;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk); // R3

  AST_CS_RISE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> done); // R3

  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R5

  AST_REFUSE_NO_CS: assert property (@(posedge clk) disable iff (rst)
    (done && rate_err) |-> spi_cs_n); // R7

  AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    !busy |-> spi_cs_n); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result)); // R12

endmodule

// File: tb/adc_conv_seq_test.sv
`timescale 1ns/1ps
module adc_conv_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_chan = '0;
  logic        req_unipolar = 1'b0;
  logic        req_single = 1'b0;
  logic [11:0] half_cfg = 12'd100;
  logic [11:0] gap_cfg = '0;
  logic        busy, done, rate_err, timeout_err;
  logic [15:0] result;
  logic        spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  adc_conv_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
    .req_unipolar(req_unipolar), .req_single(req_single),
    .half_cfg(half_cfg), .gap_cfg(gap_cfg), .busy(busy), .done(done),
    .result(result), .rate_err(rate_err), .timeout_err(timeout_err),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // converter model, polled at the falling system edge
  logic [23:0] dev_frame = '0;
  logic [23:0] dev_shift = '0;
  logic [23:0] dev_cap = '0;
  int dev_rises = 0, dev_csfalls = 0, done_cnt = 0, cyc = 0;
  int t_rise = 0, t_fall = 0;
  int hi_min = 0, hi_max = 0, lo_min = 0, lo_max = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (done) done_cnt++;
    if (prev_cs && !spi_cs_n) begin
      dev_cap = '0; dev_rises = 0; dev_csfalls++;
      dev_shift = dev_frame; spi_miso = dev_shift[23];
      t_fall = cyc; hi_min = 99999; hi_max = 0; lo_min = 99999; lo_max = 0;
    end
    if (!prev_sclk && spi_sclk) begin
      dev_cap = {dev_cap[22:0], spi_mosi}; dev_rises++;
      if (cyc - t_fall < lo_min) lo_min = cyc - t_fall;
      if (cyc - t_fall > lo_max) lo_max = cyc - t_fall;
      t_rise = cyc;
    end
    if (prev_sclk && !spi_sclk) begin
      if (cyc - t_rise < hi_min) hi_min = cyc - t_rise;
      if (cyc - t_rise > hi_max) hi_max = cyc - t_rise;
      dev_shift = {dev_shift[22:0], 1'b0}; spi_miso = dev_shift[23];
      t_fall = cyc;
    end
    prev_cs = spi_cs_n;
    prev_sclk = spi_sclk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 100000) begin
      @(negedge clk); n++;
    end
    chk(done, "R12", "done seen", int'(done), 1);
  endtask

  task automatic pulse_req(input [2:0] ch, input bit uni, input bit sgl);
    @(negedge clk);
    req_chan = ch; req_unipolar = uni; req_single = sgl; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_conv(input [2:0] ch, input bit uni, input bit sgl,
                          input int h, input int g, input [11:0] val,
                          input bit exp_to);
    logic [15:0] exp_res;
    logic [7:0]  exp_ctrl;
    int n0, d0;
    dev_frame = {8'hFF, 1'b1, val[11:5], val[4:0], 3'b111};
    half_cfg = 12'(h); gap_cfg = 12'(g);
    exp_res = uni ? {4'h0, val} : {{4{val[11]}}, val};
    exp_ctrl = {1'b1, ch, uni, sgl, 2'b11};
    n0 = dev_csfalls; d0 = done_cnt;
    pulse_req(ch, uni, sgl);
    chk(busy == 1'b1, "R11", "busy after accept", int'(busy), 1);
    wait_done();
    chk(dev_cap[23:16] == exp_ctrl, "R1", "control byte", int'(dev_cap[23:16]), int'(exp_ctrl));
    chk(dev_cap[15:0] == 16'h0, "R2", "zero bytes", int'(dev_cap[15:0]), 0);
    chk(dev_rises == 24, "R2", "rising edges", dev_rises, 24);
    chk(spi_cs_n == 1'b1, "R3", "cs high at done", int'(spi_cs_n), 1);
    chk(dev_csfalls == n0 + 1, "R3", "one cs fall", dev_csfalls, n0 + 1);
    chk(result == exp_res, uni ? "R4" : "R10", "result", int'(result), int'(exp_res));
    chk(rate_err == 1'b0, "R7", "no rate error", int'(rate_err), 0);
    chk(timeout_err == exp_to, "R9", "timeout flag", int'(timeout_err), int'(exp_to));
    chk(hi_min == h && hi_max == h, "R6", "high phase", hi_max, h);
    chk(lo_min == h, "R6", "low phase", lo_min, h);
    chk(lo_max == h + g, "R8", "byte gap low phase", lo_max, h + g);
    @(negedge clk);
    chk(!done && !busy, "R12", "done one cycle, busy cleared", int'({done, busy}), 0);
    chk(done_cnt == d0 + 1, "R12", "done count", done_cnt, d0 + 1);
    chk(result == exp_res, "R12", "result held", int'(result), int'(exp_res));
  endtask

  task automatic test_reset();
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R3", "reset bus idle",
        int'({spi_cs_n, spi_sclk}), 2);
    chk(!busy && !done, "R11", "reset not busy", int'({busy, done}), 0);
  endtask

  task automatic test_refuse(input int h);
    int n0 = dev_csfalls;
    half_cfg = 12'(h); gap_cfg = '0;
    pulse_req(3'd2, 1'b1, 1'b1);
    chk(done == 1'b1 && rate_err == 1'b1, "R7", "refused request flagged",
        int'({done, rate_err}), 3);
    chk(result == 16'h0 && !busy, "R7", "refused result and busy", int'(result), 0);
    repeat (200) @(negedge clk);
    chk(dev_csfalls == n0 && spi_cs_n, "R7", "no cs activity", dev_csfalls, n0);
  endtask

  task automatic test_busy_ignore();
    int n0 = dev_csfalls;
    dev_frame = {8'hFF, 1'b1, 7'h2A, 5'h15, 3'b111};
    half_cfg = 12'd90; gap_cfg = '0;
    pulse_req(3'd3, 1'b0, 1'b1);
    repeat (1000) @(negedge clk);
    chk(busy == 1'b1, "R11", "busy mid conversion", int'(busy), 1);
    pulse_req(3'd5, 1'b1, 1'b0);
    wait_done();
    chk(dev_cap[23:16] == 8'b1_011_0_1_11, "R11", "first request kept",
        int'(dev_cap[23:16]), 8'hB7);
    repeat (2000) @(negedge clk);
    chk(dev_csfalls == n0 + 1, "R11", "second request ignored", dev_csfalls, n0 + 1);
    chk(result == 16'h0555, "R12", "result held after idle", int'(result), 16'h0555);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_conv(3'd5, 1'b1, 1'b1, 100, 0, 12'hABC, 1'b0);   // R4 unipolar
    run_conv(3'd1, 1'b0, 1'b0, 90, 50, 12'h800, 1'b0);   // R10 negative, R8 gap
    run_conv(3'd6, 1'b0, 1'b1, 84, 7, 12'h7FF, 1'b0);    // R10 positive max, R6 min phase
    test_refuse(10);     // R7 too fast
    test_refuse(2000);   // R7 too slow
    test_busy_ignore();  // R11
    run_conv(3'd0, 1'b1, 1'b0, 600, 0, 12'h123, 1'b0);   // R9 inside ceiling
    run_conv(3'd7, 1'b1, 1'b1, 600, 1000, 12'hFED, 1'b1); // R9 gaps cross ceiling
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R12 watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule